// File: doc/BRIEF.md
# Character LCD 4-bit Initialiser and Text Writer

This block brings up a character LCD module over a four-wire data bus and then prints a short string on it. A start pulse launches a fixed run of instruction writes. The first one switches the module into 4-bit transfers. The others set entry mode and display control. After that the block reads bytes from a small on-chip character buffer and sends each one as display data. It stops at the first zero byte.

Each byte is split into two nibbles, high nibble first. Each nibble is latched by the module on the falling edge of an enable strobe. Timing is set by parameters: the setup time before each strobe, the strobe width, and a fixed settling wait after every complete byte. The wait stands in for busy-flag polling. Software fills the buffer through a write port before it pulses start. The `done` output reports that the terminator has been reached.

The sequencer walks these states. `ST_IDLE` waits for start. `ST_INIT_SEND` and `ST_INIT_STROBE` launch and finish one setup nibble. `ST_HOLD` runs the settling wait. `ST_FETCH` reads the next buffer byte. `ST_HI_SEND`, `ST_HI_STROBE`, `ST_LO_SEND` and `ST_LO_STROBE` transmit the two halves of a character. `ST_DONE` holds the finished state.

The transitions are:
- start: `ST_IDLE`/`ST_DONE` → `ST_INIT_SEND`.
- launch: each `*_SEND` state moves to its matching `*_STROBE` state.
- nibble finished in `ST_INIT_STROBE`: → `ST_HOLD` when a byte boundary follows, otherwise → `ST_INIT_SEND`.
- wait expired in `ST_HOLD`: → `ST_INIT_SEND` while setup steps remain, otherwise → `ST_FETCH`.
- fetch: `ST_FETCH` → `ST_HI_SEND` for a non-zero byte; → `ST_DONE` on a zero byte or an exhausted buffer.
- high nibble finished: `ST_HI_STROBE` → `ST_LO_SEND`.
- low nibble finished: `ST_LO_STROBE` → `ST_HOLD`.

Top module: `lcd4_text_writer`

## Requirements
- R1: `lcd_rs` is 0 whenever an instruction nibble is strobed and 1 whenever a character nibble is strobed.
- R2: For every nibble, `lcd_d` and `lcd_rs` are steady for at least SETUP_CYC cycles before `lcd_en` rises. `lcd_en` is then high for exactly HIGH_CYC cycles, and `lcd_d`/`lcd_rs` do not change while it is high.
- R3: After start, the instruction nibbles strobed are, in order: 0x2, 0x2, 0x8, 0x0, 0x6, 0x0, 0xF. These are a lone mode-switch nibble, the function-set byte 0x28, entry mode 0x06 (increment, no shift) and display control 0x0F (display, cursor and blink on).
- R4: Each byte is sent with bits 7..4 first and bits 3..0 second. Byte bit 7 (or bit 3) appears on `lcd_d[3]`, down to bit 4 (or bit 0) on `lcd_d[0]`.
- R5: After the lone first nibble and after every complete byte, `lcd_en` stays low for at least BYTE_WAIT_CYC cycles before the next strobe. Between the two nibbles of one byte, the low time is shorter than BYTE_WAIT_CYC.
- R6: Characters are sent from buffer address 0 upward. Output stops at the first zero byte, which is not sent.
- R7: If no zero byte exists, output stops after the last buffer entry (DEPTH characters).
- R8: `done` rises once the end of the string is reached, and `lcd_en` stays low from then on. A new start clears `done` within two cycles.
- R9: A start pulse while a run is in progress has no effect on the strobed nibble stream.
- R10: While `rst_n` is low, `lcd_en`, `lcd_rs`, `lcd_d` and `done` are all 0.
- R11: A cycle with `wr_en` high stores `wr_data` at buffer address `wr_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins initialisation and text output |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | AW | Buffer write address |
| wr_data | input | 8 | Buffer write byte |
| lcd_d | output | 4 | LCD data lines 7..4 |
| lcd_rs | output | 1 | Register select: 0 instruction, 1 data |
| lcd_en | output | 1 | Enable strobe, latched on falling edge |
| done | output | 1 | End of string reached |

## Verification
The string output is tried with four buffer patterns:
- A short text with a terminator shows that ordering and the stop at zero work.
- Bytes with mixed and extreme bit patterns (0xA5, 0x5A, 0xFF, 0x01, 0x80) separate a correct bit-to-line mapping from swapped or reversed nibbles.
- A zero in the first entry proves the setup sequence runs alone and nothing is printed.
- A buffer with no zero at all tells a proper end-of-buffer stop from a runaway or a wrapped read.

Every strobe is timed against the setup, width and gap rules. On top of that, directed tests cover the reset state, a start pulse in mid-run, a reset in mid-run and repeated runs without a reset.

// File: rtl/lcd4_pkg.sv
package lcd4_pkg;

    localparam int INIT_LEN = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_INIT_SEND,
        ST_INIT_STROBE,
        ST_HOLD,
        ST_FETCH,
        ST_HI_SEND,
        ST_HI_STROBE,
        ST_LO_SEND,
        ST_LO_STROBE,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SETUP,
        TX_HIGH
    } tx_state_t;

    // Setup nibble for each step of the bring-up sequence.
    function automatic logic [3:0] init_nibble(input logic [2:0] idx);
        logic [3:0] n;
        unique case (idx)
            3'd0, 3'd1: n = 4'h2;
            3'd2:       n = 4'h8;
            3'd3, 3'd5: n = 4'h0;
            3'd4:       n = 4'h6;
            default:    n = 4'hF;
        endcase
        return n;
    endfunction

    // Steps after which the settling wait must follow.
    function automatic logic init_wait_after(input logic [2:0] idx);
        return (idx[0] == 1'b0);
    endfunction

endpackage

// File: rtl/lcd4_char_buf.sv
module lcd4_char_buf #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/lcd4_nibble_strobe.sv
module lcd4_nibble_strobe
    import lcd4_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int HIGH_CYC  = 4,
    localparam int MAXC = (SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC,
    localparam int CW   = $clog2(MAXC + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [3:0] nib,
    input  logic       rs_in,
    output logic [3:0] lcd_d,
    output logic       lcd_rs,
    output logic       lcd_en,
    output logic       nib_done
);

    tx_state_t   tx_st;
    logic [CW-1:0] cnt;
    logic [3:0]  d_q;
    logic        rs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_st    <= TX_IDLE;
            cnt      <= '0;
            d_q      <= '0;
            rs_q     <= 1'b0;
            nib_done <= 1'b0;
        end else begin
            nib_done <= 1'b0;
            unique case (tx_st)
                TX_IDLE: begin
                    if (go) begin
                        d_q   <= nib;
                        rs_q  <= rs_in;
                        cnt   <= '0;
                        tx_st <= TX_SETUP;
                    end
                end
                TX_SETUP: begin
                    if (cnt == CW'(SETUP_CYC - 1)) begin
                        cnt   <= '0;
                        tx_st <= TX_HIGH;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                TX_HIGH: begin
                    if (cnt == CW'(HIGH_CYC - 1)) begin
                        cnt      <= '0;
                        nib_done <= 1'b1;
                        tx_st    <= TX_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: tx_st <= TX_IDLE;
            endcase
        end
    end

    always_comb begin
        lcd_d  = d_q;
        lcd_rs = rs_q;
        lcd_en = (tx_st == TX_HIGH);
    end

    // R2: bus lines frozen while the strobe is high
    a_r2_bus_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_en && $past(lcd_en)) |-> ($stable(lcd_d) && $stable(lcd_rs)));

    // R2: a new nibble is only launched when the strobe unit is free
    a_r2_go_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (tx_st == TX_IDLE));

endmodule

// File: rtl/lcd4_text_writer.sv
module lcd4_text_writer
    import lcd4_pkg::*;
#(
    parameter int DEPTH         = 16,
    parameter int SETUP_CYC     = 2,
    parameter int HIGH_CYC      = 4,
    parameter int BYTE_WAIT_CYC = 4000,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1,
    localparam int HW = $clog2(BYTE_WAIT_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    output logic [3:0]    lcd_d,
    output logic          lcd_rs,
    output logic          lcd_en,
    output logic          done
);

    seq_state_t    st, st_n;
    logic [2:0]    step;
    logic [PW-1:0] ptr;
    logic [HW-1:0] hold_cnt;
    logic [7:0]    char_q;
    logic [7:0]    buf_byte;
    logic          tx_go, tx_rs, tx_done;
    logic [3:0]    tx_nib;
    logic          at_end;
    logic          hold_over;

    lcd4_char_buf #(.DEPTH(DEPTH)) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (ptr[AW-1:0]),
        .rd_data (buf_byte)
    );

    lcd4_nibble_strobe #(.SETUP_CYC(SETUP_CYC), .HIGH_CYC(HIGH_CYC)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (tx_go),
        .nib      (tx_nib),
        .rs_in    (tx_rs),
        .lcd_d    (lcd_d),
        .lcd_rs   (lcd_rs),
        .lcd_en   (lcd_en),
        .nib_done (tx_done)
    );

    assign at_end    = (ptr == PW'(DEPTH)) || (buf_byte == 8'h00);
    assign hold_over = (hold_cnt == HW'(BYTE_WAIT_CYC - 1));

    // Next-state logic
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE, ST_DONE: if (start) st_n = ST_INIT_SEND;
            ST_INIT_SEND:     st_n = ST_INIT_STROBE;
            ST_INIT_STROBE: begin
                if (tx_done) st_n = init_wait_after(step) ? ST_HOLD : ST_INIT_SEND;
            end
            ST_HOLD: begin
                if (hold_over) st_n = (step == 3'(INIT_LEN)) ? ST_FETCH : ST_INIT_SEND;
            end
            ST_FETCH:         st_n = at_end ? ST_DONE : ST_HI_SEND;
            ST_HI_SEND:       st_n = ST_HI_STROBE;
            ST_HI_STROBE:     if (tx_done) st_n = ST_LO_SEND;
            ST_LO_SEND:       st_n = ST_LO_STROBE;
            ST_LO_STROBE:     if (tx_done) st_n = ST_HOLD;
            default:          st_n = ST_IDLE;
        endcase
    end

    // State register and step bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            step     <= '0;
            ptr      <= '0;
            hold_cnt <= '0;
            char_q   <= '0;
            done     <= 1'b0;
        end else begin
            st <= st_n;
            unique case (st)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        step <= '0;
                        ptr  <= '0;
                        done <= 1'b0;
                    end
                end
                ST_INIT_STROBE: begin
                    if (tx_done) begin
                        step     <= step + 3'd1;
                        hold_cnt <= '0;
                    end
                end
                ST_HOLD:  hold_cnt <= hold_cnt + 1'b1;
                ST_FETCH: begin
                    if (at_end) done <= 1'b1;
                    else        char_q <= buf_byte;
                end
                ST_LO_STROBE: begin
                    if (tx_done) begin
                        ptr      <= ptr + 1'b1;
                        hold_cnt <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Output decode toward the strobe unit
    always_comb begin
        tx_go  = 1'b0;
        tx_rs  = 1'b0;
        tx_nib = 4'h0;
        unique case (st)
            ST_INIT_SEND: begin
                tx_go  = 1'b1;
                tx_nib = init_nibble(step);
            end
            ST_HI_SEND: begin
                tx_go  = 1'b1;
                tx_rs  = 1'b1;
                tx_nib = char_q[7:4];
            end
            ST_LO_SEND: begin
                tx_go  = 1'b1;
                tx_rs  = 1'b1;
                tx_nib = char_q[3:0];
            end
            default: ;
        endcase
    end

    // R1: instruction strobes carry register-select low
    a_r1_rs_instr: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_en && st == ST_INIT_STROBE) |-> !lcd_rs);

    // R1: character strobes carry register-select high
    a_r1_rs_text: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_en && (st == ST_HI_STROBE || st == ST_LO_STROBE)) |-> lcd_rs);

    // R8: no strobe once the string is finished
    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !lcd_en);

    // R7: read pointer never passes the end of the buffer
    a_r7_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= PW'(DEPTH));

endmodule

// File: tb/lcd4_text_writer_tb.sv
`timescale 1ns/1ps
module lcd4_text_writer_tb;

    localparam int DEPTH = 8;
    localparam int SETUP = 2;
    localparam int HIGHC = 3;
    localparam int WAITC = 12;
    localparam int AW    = $clog2(DEPTH);
    localparam int NV    = 4;
    localparam logic [63:0] VEC [NV] = '{
        64'h0000_0000_0021_6948,
        64'h0000_0080_01FF_5AA5,
        64'h4142_4344_4546_4700,
        64'h7E31_C311_99F0_0F42
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [3:0]    lcd_d;
    logic          lcd_rs;
    logic          lcd_en;
    logic          done;

    lcd4_text_writer #(.DEPTH(DEPTH), .SETUP_CYC(SETUP), .HIGH_CYC(HIGHC),
                       .BYTE_WAIT_CYC(WAITC)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .lcd_d(lcd_d),
        .lcd_rs(lcd_rs), .lcd_en(lcd_en), .done(done)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    // Strobe monitor, sampled on the falling clock edge
    logic [4:0] cap [64];
    int         gap [64];
    int         ncap = 0;
    int         bad_width = 0, bad_setup = 0, bad_stable = 0;
    int         low_cnt = 0, high_cnt = 0, stable_cnt = 0;
    logic       prev_en = 1'b0;
    logic [4:0] prev_bus = '0;

    always @(negedge clk) begin
        cycles++;
        if ({lcd_rs, lcd_d} != prev_bus) begin
            if (lcd_en && prev_en) bad_stable++;
            stable_cnt = 0;
        end else if (stable_cnt < 1000) begin
            stable_cnt++;
        end
        if (lcd_en && !prev_en) begin
            if (stable_cnt < SETUP) bad_setup++;
            if (ncap < 64) gap[ncap] = low_cnt;
            high_cnt = 1;
        end else if (lcd_en) begin
            high_cnt++;
        end else if (prev_en) begin
            if (high_cnt != HIGHC) bad_width++;
            if (ncap < 64) cap[ncap] = prev_bus;
            ncap++;
            low_cnt = 1;
        end else begin
            low_cnt++;
        end
        prev_en  = lcd_en;
        prev_bus = {lcd_rs, lcd_d};
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_byte(input int a, input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(done, "R8 done timeout", int'(done), 1);
    endtask

    task automatic clear_mon();
        @(posedge clk);
        ncap = 0; bad_width = 0; bad_setup = 0; bad_stable = 0;
    endtask

    // Global watchdog
    initial begin
        wait (cycles > 150000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [4:0] exp_nib [64];
        int ne;
        logic stop;
        logic [7:0] b;
        logic [3:0] init_seq [7];
        init_seq = '{4'h2, 4'h2, 4'h8, 4'h0, 4'h6, 4'h0, 4'hF};

        // R10: reset state
        repeat (3) @(negedge clk);
        chk(!lcd_en && !lcd_rs && lcd_d == 4'h0 && !done, "R10 reset outputs",
            {lcd_en, lcd_rs, lcd_d, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            for (int a = 0; a < DEPTH; a++) write_byte(a, VEC[v][a*8 +: 8]);
            ne = 0;
            for (int i = 0; i < 7; i++) begin
                exp_nib[ne] = {1'b0, init_seq[i]};
                ne++;
            end
            stop = 1'b0;
            for (int a = 0; a < DEPTH; a++) begin
                b = VEC[v][a*8 +: 8];
                if (b == 8'h00) stop = 1'b1;
                if (!stop) begin
                    exp_nib[ne] = {1'b1, b[7:4]}; ne++;
                    exp_nib[ne] = {1'b1, b[3:0]}; ne++;
                end
            end
            clear_mon();
            pulse_start();
            @(negedge clk);
            if (v > 0) chk(!done, "R8 done cleared by start", int'(done), 0);
            if (v == 1) begin
                repeat (60) @(negedge clk);
                pulse_start();     // R9: ignored mid-run
            end
            wait_done();
            repeat (40) @(negedge clk);
            chk(done && !lcd_en, "R8 done held, strobe idle", {done, lcd_en}, 2);
            chk(ncap == ne, (v == 3) ? "R7 nibble count" : "R6/R9 nibble count", ncap, ne);
            for (int i = 0; i < ne && i < ncap; i++) begin
                chk(cap[i][4] == exp_nib[i][4], "R1 register select", cap[i][4], exp_nib[i][4]);
                chk(cap[i][3:0] == exp_nib[i][3:0], (i < 7) ? "R3 setup nibble" : "R4 char nibble",
                    cap[i][3:0], exp_nib[i][3:0]);
                if (i > 0) begin
                    logic lng;
                    lng = (i < 7) ? (i % 2 == 1) : ((i - 7) % 2 == 0);
                    chk((gap[i] >= WAITC) == lng, "R5 strobe gap", gap[i], lng ? WAITC : 0);
                end
            end
            chk(bad_width == 0, "R2 strobe width", bad_width, 0);
            chk(bad_setup == 0, "R2 setup time", bad_setup, 0);
            chk(bad_stable == 0, "R2 bus stable", bad_stable, 0);
        end

        // R11: a rewritten entry appears in the next run
        write_byte(0, 8'h3C);
        write_byte(1, 8'h00);
        clear_mon();
        pulse_start();
        wait_done();
        repeat (5) @(negedge clk);
        chk(ncap == 9, "R11 count after rewrite", ncap, 9);
        chk(cap[7] == 5'h13 && cap[8] == 5'h1C, "R11 rewritten byte", {cap[7], cap[8]}, 10'h27C);

        // R10: reset in the middle of a run
        pulse_start();
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!lcd_en && !lcd_rs && lcd_d == 4'h0 && !done, "R10 mid-run reset",
            {lcd_en, lcd_rs, lcd_d, done}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule